// File: doc/BRIEF.md
# Frame Slot Match/Mask Event Selector

This block watches a stream of command frames. Each frame carries three command slot words, A, B and C. Three programmable patterns are applied to the slot words, and each pattern has a match value and a mask. Comparing every pattern against every slot gives nine hit signals. Three event outputs each choose one condition from those hits through a 4-bit code. A code can ask for one pattern in one slot, for one pattern in any slot, or for a whole-frame match. The whole-frame match needs pattern 0 in slot A, pattern 1 in slot B and pattern 2 in slot C, all at once. The event pulses drive performance or debug counters that sit outside this block.

Software sets up the patterns and the three codes through a word-wide write/read port. The pattern and select registers are sticky: a soft reset leaves them unchanged and clears only the event outputs. Only a power-on reset restores the register defaults.

Top module: `frame_slot_event_sel`

## Requirements
- R1: A slot word hits a pattern when every bit whose mask bit is 1 equals the pattern's match bit. Bits whose mask bit is 0 are ignored.
- R2: A pattern with an all-zero mask hits every slot of every valid frame.
- R3: In the select register (word address 12), bits [3:0] hold the code for event 0, bits [7:4] the code for event 1 and bits [11:8] the code for event 2. Bits [31:12] are not stored and read as zero.
- R4: Codes 0h to 8h each select one pattern in one slot, written as (pattern, slot): 0h=(1,A), 1h=(2,A), 2h=(0,A), 3h=(2,B), 4h=(0,B), 5h=(1,B), 6h=(0,C), 7h=(1,C), 8h=(2,C).
- R5: Codes 9h, Ah and Bh select pattern 0, pattern 1 and pattern 2 respectively, hitting in any of slots A, B or C.
- R6: Code Ch fires only when slot A hits pattern 0, slot B hits pattern 1 and slot C hits pattern 2, all in the same frame.
- R7: Codes Dh, Eh and Fh never produce an event.
- R8: An event output is high for exactly one cycle, in the cycle after a frame-valid cycle whose slots meet the selected condition. It is low whenever the previous cycle had no frame-valid.
- R9: After power-on reset all match words are zero. The mask words are zero except for the lower mask word of pattern 1, which is 00100000h, and the lower mask word of pattern 2, which is 001FC000h. The select register reads 000002A3h. All events are low.
- R10: Soft reset clears the event outputs, including the pulse for a frame presented while it is asserted. It leaves every match, mask and select register unchanged.
- R11: Pattern p occupies word addresses 4p to 4p+3, in this order: match low, match high, mask low, mask high. Addresses 13 to 15 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; restores all defaults |
| soft_rst_n | input | 1 | Soft reset, active low, synchronous; clears events only |
| frame_vld | input | 1 | The slot words hold a frame this cycle |
| slot_a | input | 64 | Command slot A |
| slot_b | input | 64 | Command slot B |
| slot_c | input | 64 | Command slot C |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| evt | output | 3 | Event pulses; bit e follows the code for event e |

## Verification
The bench builds the block with its default parameters: 64-bit slot words split into two 32-bit register words. With these defaults every register address, including the unmapped ones, can be reached, and the upper and lower halves of each pattern can be checked separately. Random slot words are built by copying a pattern's masked bits and filling the bits outside the mask with noise. Hits on narrow and wide masks are therefore common, and all sixteen select codes can be tried on all three event outputs.

// File: rtl/frame_slot_event_sel.sv
module frame_slot_event_sel #(
  parameter int SLOT_W = 64,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst_n,
  input  logic              frame_vld,
  input  logic [SLOT_W-1:0] slot_a,
  input  logic [SLOT_W-1:0] slot_b,
  input  logic [SLOT_W-1:0] slot_c,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [2:0]        evt
);
  localparam int WORDS    = SLOT_W / REG_W;
  localparam int PAT_SPAN = 2 * WORDS;
  localparam int SEL_ADDR = 3 * PAT_SPAN;
  localparam logic [11:0] SEL_RST = 12'h2A3;

  logic [SLOT_W-1:0] match_q [3];
  logic [SLOT_W-1:0] mask_q  [3];
  logic [SLOT_W-1:0] slot    [3];
  logic [11:0]       sel_q;
  logic [8:0]        hit;
  logic [2:0]        evt_q;

  function automatic logic [SLOT_W-1:0] mask_default(input int p);
    case (p)
      1:       return SLOT_W'(32'h0010_0000);
      2:       return SLOT_W'(32'h001F_C000);
      default: return '0;
    endcase
  endfunction

  // hit index = pattern*3 + slot, slot A=0 B=1 C=2
  function automatic logic pick(input logic [3:0] code, input logic [8:0] h);
    case (code)
      4'h0: return h[3];
      4'h1: return h[6];
      4'h2: return h[0];
      4'h3: return h[7];
      4'h4: return h[1];
      4'h5: return h[4];
      4'h6: return h[2];
      4'h7: return h[5];
      4'h8: return h[8];
      4'h9: return |h[2:0];
      4'hA: return |h[5:3];
      4'hB: return |h[8:6];
      4'hC: return h[0] & h[4] & h[8];
      default: return 1'b0;
    endcase
  endfunction

  assign slot[0] = slot_a;
  assign slot[1] = slot_b;
  assign slot[2] = slot_c;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int p = 0; p < 3; p++) begin
        match_q[p] <= '0;
        mask_q[p]  <= mask_default(p);
      end
      sel_q <= SEL_RST;
    end else if (reg_we) begin
      for (int p = 0; p < 3; p++) begin
        for (int w = 0; w < WORDS; w++) begin
          if (reg_addr == ADDR_W'(p * PAT_SPAN + w))
            match_q[p][w*REG_W +: REG_W] <= reg_wdata;
          if (reg_addr == ADDR_W'(p * PAT_SPAN + WORDS + w))
            mask_q[p][w*REG_W +: REG_W] <= reg_wdata;
        end
      end
      if (reg_addr == ADDR_W'(SEL_ADDR))
        sel_q <= reg_wdata[11:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < 3; p++) begin
      for (int w = 0; w < WORDS; w++) begin
        if (reg_addr == ADDR_W'(p * PAT_SPAN + w))
          reg_rdata = match_q[p][w*REG_W +: REG_W];
        if (reg_addr == ADDR_W'(p * PAT_SPAN + WORDS + w))
          reg_rdata = mask_q[p][w*REG_W +: REG_W];
      end
    end
    if (reg_addr == ADDR_W'(SEL_ADDR))
      reg_rdata = REG_W'(sel_q);
  end

  for (genvar p = 0; p < 3; p++) begin : g_pat
    for (genvar s = 0; s < 3; s++) begin : g_slot
      assign hit[p*3+s] = ~|((slot[s] ^ match_q[p]) & mask_q[p]);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      evt_q <= '0;
    else if (!soft_rst_n)
      evt_q <= '0;
    else
      for (int e = 0; e < 3; e++)
        evt_q[e] <= frame_vld & pick(sel_q[4*e +: 4], hit);
  end

  assign evt = evt_q;
endmodule

module frame_slot_event_sel_chk (
  input logic        clk,
  input logic        por_n,
  input logic        soft_rst_n,
  input logic        frame_vld,
  input logic        reg_we,
  input logic [3:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic [11:0] sel_q,
  input logic [2:0]  evt
);
  // R8
  evt_needs_frame_chk: assert property (@(posedge clk) disable iff (!por_n)
    !frame_vld |=> evt == 3'b000);

  // R10
  soft_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    !soft_rst_n |=> evt == 3'b000);

  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !reg_we |=> $stable(sel_q));

  // R3
  sel_upper_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    reg_addr == 4'd12 |-> reg_rdata[31:12] == 20'h0);

  for (genvar e = 0; e < 3; e++) begin : g_rsv
    // R7
    rsvd_code_chk: assert property (@(posedge clk) disable iff (!por_n)
      (frame_vld && sel_q[4*e +: 4] >= 4'hD) |=> !evt[e]);
  end
endmodule

bind frame_slot_event_sel frame_slot_event_sel_chk u_chk (
  .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .frame_vld(frame_vld),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .sel_q(sel_q), .evt(evt)
);

// File: tb/frame_slot_event_sel_tb.sv
module frame_slot_event_sel_tb;
  logic        clk = 0;
  logic        por_n = 0;
  logic        soft_rst_n = 0;
  logic        frame_vld = 0;
  logic [63:0] slot_a = '0, slot_b = '0, slot_c = '0;
  logic        reg_we = 0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  evt;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [63:0] m_match [3];
  logic [63:0] m_mask  [3];
  logic [11:0] m_sel;

  always #10 clk = ~clk;

  frame_slot_event_sel u_dut (
    .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .frame_vld(frame_vld),
    .slot_a(slot_a), .slot_b(slot_b), .slot_c(slot_c),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt(evt)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit ref_hit(input int p, input logic [63:0] s);
    return ((s ^ m_match[p]) & m_mask[p]) == 64'h0;
  endfunction

  function automatic bit ref_evt(input logic [3:0] code, input logic [63:0] a, b, c);
    bit h [3][3];
    for (int p = 0; p < 3; p++) begin
      h[p][0] = ref_hit(p, a); h[p][1] = ref_hit(p, b); h[p][2] = ref_hit(p, c);
    end
    case (code)
      4'h0: return h[1][0];
      4'h1: return h[2][0];
      4'h2: return h[0][0];
      4'h3: return h[2][1];
      4'h4: return h[0][1];
      4'h5: return h[1][1];
      4'h6: return h[0][2];
      4'h7: return h[1][2];
      4'h8: return h[2][2];
      4'h9: return h[0][0] | h[0][1] | h[0][2];
      4'hA: return h[1][0] | h[1][1] | h[1][2];
      4'hB: return h[2][0] | h[2][1] | h[2][2];
      4'hC: return h[0][0] & h[1][1] & h[2][2];
      default: return 1'b0;
    endcase
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic set_pat(input int p, input logic [63:0] mt, input logic [63:0] mk);
    wr(4'(4*p), mt[31:0]);   wr(4'(4*p+1), mt[63:32]);
    wr(4'(4*p+2), mk[31:0]); wr(4'(4*p+3), mk[63:32]);
    m_match[p] = mt; m_mask[p] = mk;
  endtask

  task automatic set_sel(input logic [31:0] v);
    wr(4'd12, v);
    m_sel = v[11:0];
  endtask

  task automatic frame(input logic [63:0] a, b, c, input string req);
    logic [2:0] exp;
    @(negedge clk);
    frame_vld = 1; slot_a = a; slot_b = b; slot_c = c;
    for (int e = 0; e < 3; e++) exp[e] = ref_evt(m_sel[4*e +: 4], a, b, c);
    @(negedge clk);
    frame_vld = 0;
    chk(evt == exp, req, 64'(evt), 64'(exp));
    @(negedge clk);
    chk(evt == 3'b000, "R8 pulse one cycle", 64'(evt), 64'h0);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [63:0] near(input int p);
    return (m_match[p] & m_mask[p]) | (r64() & ~m_mask[p]);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    por_n = 1; soft_rst_n = 1;
    @(negedge clk);
    // R9 power-on defaults
    chk(evt == 3'b000, "R9 evt reset", 64'(evt), 64'h0);
    for (int a = 0; a < 12; a++) begin
      logic [31:0] e;
      e = (a == 6) ? 32'h0010_0000 : (a == 10) ? 32'h001F_C000 : 32'h0;
      rd_chk(4'(a), e, "R9 pattern default");
    end
    rd_chk(4'd12, 32'h0000_02A3, "R9 select default");
    for (int p = 0; p < 3; p++) m_match[p] = '0;
    m_mask[0] = '0; m_mask[1] = 64'h0010_0000; m_mask[2] = 64'h001F_C000;
    m_sel = 12'h2A3;
    // R8 no frame: no event
    repeat (2) @(negedge clk);
    chk(evt == 3'b000, "R8 idle", 64'(evt), 64'h0);

    // R3 field layout, upper bits dropped
    set_sel(32'hFFFF_F5C9);
    rd_chk(4'd12, 32'h0000_05C9, "R3 select readback");
    // R11 map and unmapped addresses
    set_pat(1, 64'h1111_2222_3333_4444, 64'hFFFF_0000_0000_FFFF);
    rd_chk(4'd4, 32'h3333_4444, "R11 match low");
    rd_chk(4'd5, 32'h1111_2222, "R11 match high");
    rd_chk(4'd6, 32'h0000_FFFF, "R11 mask low");
    rd_chk(4'd7, 32'hFFFF_0000, "R11 mask high");
    for (int a = 13; a < 16; a++) begin
      wr(4'(a), 32'hDEAD_BEEF);
      rd_chk(4'(a), 32'h0, "R11 unmapped");
    end
    rd_chk(4'd12, 32'h0000_05C9, "R11 select untouched");

    // R1 mask semantics: flipping a masked-out bit still hits, masked-in bit misses
    set_pat(0, 64'hA5A5_0000_0000_5A5A, 64'h0000_0000_0000_00FF);
    set_sel(32'h0000_0922);  // evt0=(0,A) evt1=(0,A) evt2=p0 any
    frame(64'hFFFF_FFFF_FFFF_FF5A, '1, '1, "R1 masked-out bits ignored");
    frame(64'h0000_0000_0000_005B, '1, '1, "R1 masked-in bit compared");
    chk(ref_evt(4'h2, 64'h5B, '1, '1) == 1'b0, "R1 model miss", 0, 0);

    // R2 all-zero masks hit everything; R5/R6 all fire
    set_pat(0, r64(), '0); set_pat(1, r64(), '0); set_pat(2, r64(), '0);
    set_sel(32'h0000_0CAB);
    frame(r64(), r64(), r64(), "R2 zero mask any-slot/frame");
    // R7 reserved codes never fire even when everything matches
    set_sel(32'h0000_0DEF);
    frame(r64(), r64(), r64(), "R7 reserved codes");

    // R6 frame match needs every slot in place
    set_pat(0, 64'h0123_4567_89AB_CDEF, '1);
    set_pat(1, 64'hFEDC_BA98_7654_3210, '1);
    set_pat(2, 64'h0F0F_0F0F_F0F0_F0F0, '1);
    set_sel(32'h0000_0CCC);
    frame(m_match[0], m_match[1], m_match[2], "R6 full frame hit");
    chk(evt == 0, "R6 pre", 64'(evt), 0);
    frame(m_match[0], m_match[1], m_match[1], "R6 slot C wrong");
    frame(m_match[1], m_match[1], m_match[2], "R6 slot A wrong");
    // R4 stated single-slot codes, R5 any-slot
    set_sel(32'h0000_02A3);
    frame(m_match[0], m_match[2], '0, "R4 codes 2h 3h");
    frame('0, '0, m_match[1], "R5 code Ah slot C");

    // R10 soft reset: clears pulse, keeps registers
    set_sel(32'h0000_0CCC);
    @(negedge clk);
    frame_vld = 1; slot_a = m_match[0]; slot_b = m_match[1]; slot_c = m_match[2];
    soft_rst_n = 0;
    @(negedge clk);
    frame_vld = 0;
    chk(evt == 3'b000, "R10 pulse suppressed", 64'(evt), 0);
    soft_rst_n = 1;
    rd_chk(4'd12, 32'h0000_0CCC, "R10 select kept");
    rd_chk(4'd0, m_match[0][31:0], "R10 match kept");
    rd_chk(4'd11, 32'hFFFF_FFFF, "R10 mask kept");

    // R4 R5 R6 R7 random sweep
    for (int i = 0; i < 250; i++) begin
      logic [63:0] s [3];
      if (i % 25 == 0)
        for (int p = 0; p < 3; p++) begin
          logic [63:0] mk;
          case ($urandom % 3)
            0: mk = r64();
            1: mk = r64() & r64() & r64();
            default: mk = 64'(1) << ($urandom % 64);
          endcase
          set_pat(p, r64(), mk);
        end
      if (i % 5 == 0) set_sel($urandom);
      for (int k = 0; k < 3; k++)
        s[k] = ($urandom % 4 == 0) ? r64() : near($urandom % 3);
      if (i % 7 == 0) begin s[0] = near(0); s[1] = near(1); s[2] = near(2); end
      frame(s[0], s[1], s[2], "R4 R5 R6 R7 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule